// File: doc/BRIEF.md
# Vector Integer Compare-with-Zero, Absolute and Negate Unit

This unit executes a small family of vector integer operations, one source register to one destination register, on a 128-bit register value. It takes a 32-bit instruction word and the 128-bit source operand. It decodes which operation to run, the element width and whether the full vector or only its lower half is used. It then produces the destination value, a write strobe and the destination register index, one clock cycle later.

Five operations compare each element with zero and return a per-element mask. The mask is all ones when the test holds and all zeros when it does not. The two remaining operations are absolute value and negation. Both wrap modulo the element width and never saturate. Encodings the unit does not implement, and the forbidden pairing of 64-bit elements with a half-width vector, raise a flag and block the write. The register file sits outside this unit. The unit drives the source index so the register file can read the operand, and the caller returns that operand on the same cycle as the instruction.

Top module: `vmisc_unit`

## Requirements
- R1: The instruction fields are decoded from these bit positions: operation code in bits [16:12], element size in bits [23:22] (0=8, 1=16, 2=32, 3=64 bits), variant bit in bit 29, full-width bit in bit 30, source register in bits [9:5] and destination register in bits [4:0]. `src_idx` is the source field, combinationally. `rd_idx` is the destination field of the accepted instruction, registered.
- R2: Operation code 0x8 tests greater than zero (variant 0) or greater-or-equal zero (variant 1). Code 0x9 tests equal to zero (variant 0). All comparisons are signed per element. Each element of the result is all ones when the test holds and zero when it does not.
- R3: Code 0x9 with variant 1 tests less-or-equal zero. Code 0xA tests less than zero. Both are evaluated by swapping the operands of the greater-or-equal and greater-than tests, so zero becomes the left operand.
- R4: Code 0xB with variant 0 gives the absolute value: the element itself when it is greater than zero, and its two's-complement negation otherwise. The most negative value maps to itself.
- R5: Code 0xB with variant 1 gives the two's-complement negation modulo the element width. The most negative value maps to itself.
- R6: Element size 3 with full-width bit 0, for any supported code, raises `undef_flag`. It gives `wr_en`=0 and a zero result.
- R7: Any code outside 0x8 to 0xB raises `unsup_flag`. It gives `wr_en`=0, a zero result and `undef_flag`=0.
- R8: With full-width bit 1 all 128 bits are processed. With full-width bit 0 only bits [63:0] are processed, and bits [127:64] of the result are zero.
- R9: Every element of the selected width is processed on its own, with no carry or borrow crossing element boundaries, for 8-, 16-, 32- and 64-bit elements.
- R10: `out_valid` is `in_valid` delayed by one clock cycle. While reset is active (rst_n low), every output register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction and operand are present this cycle |
| instr | input | 32 | Instruction word |
| src | input | 128 | Source register value |
| src_idx | output | 5 | Source register index, combinational from `instr` |
| out_valid | output | 1 | Result cycle for the previous accepted instruction |
| wr_en | output | 1 | Destination write strobe |
| rd_idx | output | 5 | Destination register index |
| result | output | 128 | Destination value |
| undef_flag | output | 1 | Forbidden size and width pairing |
| unsup_flag | output | 1 | Operation code not implemented |

## Verification
The decoded operation, element size and width mode live for only one cycle before the output register. A wrong decode therefore shows at the ports on the very next cycle: wrong mask polarity, a mask that is neither all ones nor all zeros in some byte, a lane boundary that leaks a borrow, or nonzero upper bits in half-width mode. The test vectors set the most negative value, zero, plus one and minus one in neighbouring elements. This exposes a swapped comparison operand, a saturating absolute value or a carry that crosses a lane, all within that single cycle. The flag paths are checked by confirming that the write strobe falls and the result stays zero in the cycle where each flag rises.

// File: rtl/vmisc_pkg.sv
package vmisc_pkg;
  localparam int VEC_W   = 128;
  localparam int HALF_W  = VEC_W / 2;
  localparam int IDX_W   = 5;
  localparam int NUM_SZ  = 4;

  typedef enum logic [2:0] {
    OP_GT  = 3'd0,
    OP_GE  = 3'd1,
    OP_EQ  = 3'd2,
    OP_LE  = 3'd3,
    OP_LT  = 3'd4,
    OP_ABS = 3'd5,
    OP_NEG = 3'd6,
    OP_NONE = 3'd7
  } vop_e;

  function automatic logic op_is_cmp(vop_e op);
    return (op == OP_GT) || (op == OP_GE) || (op == OP_EQ) ||
           (op == OP_LE) || (op == OP_LT);
  endfunction
endpackage

// File: rtl/vmisc_decode.sv
module vmisc_decode
  import vmisc_pkg::*;
(
  input  logic [31:0]      instr,
  output vop_e             op,
  output logic [1:0]       size,
  output logic             full,
  output logic [IDX_W-1:0] rn,
  output logic [IDX_W-1:0] rd,
  output logic             undef,
  output logic             unsup
);
  logic [4:0] opc;
  logic       var_bit;
  logic       known;
  logic [13:0] unused_fields;

  assign opc     = instr[16:12];
  assign var_bit = instr[29];
  assign full    = instr[30];
  assign size    = instr[23:22];
  assign rn      = instr[9:5];
  assign rd      = instr[4:0];
  assign unused_fields = {instr[31], instr[28:24], instr[21:17], instr[11:10]};

  always_comb begin
    known = 1'b1;
    unique case (opc)
      5'h08:   op = var_bit ? OP_GE  : OP_GT;
      5'h09:   op = var_bit ? OP_LE  : OP_EQ;
      5'h0A:   op = OP_LT;
      5'h0B:   op = var_bit ? OP_NEG : OP_ABS;
      default: begin op = OP_NONE; known = 1'b0; end
    endcase
  end

  assign unsup = !known;
  assign undef = known && (size == 2'd3) && !full;
endmodule

// File: rtl/vmisc_lanes.sv
module vmisc_lanes
  import vmisc_pkg::*;
#(
  parameter int EW = 8,
  parameter int VW = VEC_W
) (
  input  vop_e          op,
  input  logic [VW-1:0] src,
  output logic [VW-1:0] res
);
  localparam int LANES = VW / EW;

  function automatic logic sgt(logic [EW-1:0] a, logic [EW-1:0] b);
    return $signed(a) > $signed(b);
  endfunction

  function automatic logic sge(logic [EW-1:0] a, logic [EW-1:0] b);
    return $signed(a) >= $signed(b);
  endfunction

  function automatic logic [EW-1:0] wrap_neg(logic [EW-1:0] a);
    return EW'(~a + EW'(1));
  endfunction

  function automatic logic [EW-1:0] lane_op(vop_e o, logic [EW-1:0] a);
    logic [EW-1:0] z;
    logic hit;
    z   = '0;
    hit = 1'b0;
    case (o)
      OP_GT:  hit = sgt(a, z);
      OP_GE:  hit = sge(a, z);
      OP_EQ:  hit = (a == z);
      OP_LE:  hit = sge(z, a);
      OP_LT:  hit = sgt(z, a);
      default: hit = 1'b0;
    endcase
    case (o)
      OP_ABS:  return sgt(a, z) ? a : wrap_neg(a);
      OP_NEG:  return wrap_neg(a);
      OP_NONE: return '0;
      default: return {EW{hit}};
    endcase
  endfunction

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign res[i*EW +: EW] = lane_op(op, src[i*EW +: EW]);
  end
endmodule

// File: rtl/vmisc_unit.sv
module vmisc_unit
  import vmisc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       instr,
  input  logic [VEC_W-1:0]  src,
  output logic [IDX_W-1:0]  src_idx,
  output logic              out_valid,
  output logic              wr_en,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [VEC_W-1:0]  result,
  output logic              undef_flag,
  output logic              unsup_flag
);
  vop_e             dec_op;
  logic [1:0]       dec_size;
  logic             dec_full;
  logic [IDX_W-1:0] dec_rd;
  logic             dec_undef;
  logic             dec_unsup;

  vmisc_decode i_dec (
    .instr (instr),
    .op    (dec_op),
    .size  (dec_size),
    .full  (dec_full),
    .rn    (src_idx),
    .rd    (dec_rd),
    .undef (dec_undef),
    .unsup (dec_unsup)
  );

  logic [VEC_W-1:0] by_size [NUM_SZ];

  for (genvar g = 0; g < NUM_SZ; g++) begin : g_size
    vmisc_lanes #(.EW(8 << g), .VW(VEC_W)) i_lanes (
      .op  (dec_op),
      .src (src),
      .res (by_size[g])
    );
  end

  // named events for the checker
  logic             write_ok;
  logic [VEC_W-1:0] next_result;
  logic             out_is_cmp;

  assign write_ok = !dec_undef && !dec_unsup;

  always_comb begin
    next_result = write_ok ? by_size[dec_size] : '0;
    if (!dec_full) next_result[VEC_W-1:HALF_W] = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      wr_en      <= 1'b0;
      rd_idx     <= '0;
      result     <= '0;
      undef_flag <= 1'b0;
      unsup_flag <= 1'b0;
      out_is_cmp <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      wr_en      <= in_valid && write_ok;
      rd_idx     <= in_valid ? dec_rd : '0;
      result     <= in_valid ? next_result : '0;
      undef_flag <= in_valid && dec_undef;
      unsup_flag <= in_valid && dec_unsup;
      out_is_cmp <= in_valid && op_is_cmp(dec_op);
    end
  end
endmodule

// File: rtl/vmisc_checker.sv
module vmisc_checker
  import vmisc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [31:0]      instr,
  input logic             out_valid,
  input logic             wr_en,
  input logic [VEC_W-1:0] result,
  input logic             undef_flag,
  input logic             unsup_flag,
  input logic             out_is_cmp
);
  localparam int NBYTES = VEC_W / 8;
  logic [NBYTES-1:0] byte_ok;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign byte_ok[b] = (result[b*8 +: 8] == 8'h00) || (result[b*8 +: 8] == 8'hFF);
  end

  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !wr_en);
  a_r6_undef_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    undef_flag |-> !wr_en && out_valid && result == '0);
  a_r7_unsup_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    unsup_flag |-> !wr_en && !undef_flag && result == '0);
  a_r6_decode_undef: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[23:22] == 2'd3 && !instr[30] &&
     instr[16:12] >= 5'h08 && instr[16:12] <= 5'h0B) |=> undef_flag);
  a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !instr[30]) |=> result[VEC_W-1:HALF_W] == '0);
  a_r2_mask_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && out_is_cmp) |-> &byte_ok);
endmodule

bind vmisc_unit vmisc_checker i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .instr      (instr),
  .out_valid  (out_valid),
  .wr_en      (wr_en),
  .result     (result),
  .undef_flag (undef_flag),
  .unsup_flag (unsup_flag),
  .out_is_cmp (out_is_cmp)
);

// File: tb/test_vmisc_unit.sv
module test_vmisc_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [31:0]  instr = '0;
  logic [127:0] src = '0;
  logic [4:0]   src_idx;
  logic         out_valid;
  logic         wr_en;
  logic [4:0]   rd_idx;
  logic [127:0] result;
  logic         undef_flag;
  logic         unsup_flag;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vmisc_unit i_vmisc_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .src(src),
    .src_idx(src_idx), .out_valid(out_valid), .wr_en(wr_en), .rd_idx(rd_idx),
    .result(result), .undef_flag(undef_flag), .unsup_flag(unsup_flag)
  );

  // entry: {full, var, size[1:0], opcode[4:0], src[127:0]}
  localparam int NV = 16;
  localparam logic [136:0] VEC [NV] = '{
    {1'b1, 1'b0, 2'd0, 5'h08, 128'h807F0001FF10F000_0102030405060708},
    {1'b1, 1'b1, 2'd1, 5'h08, 128'h80007FFF0000FFFF_0001800100020000},
    {1'b1, 1'b0, 2'd2, 5'h09, 128'h00000000_00000001_80000000_00000000},
    {1'b1, 1'b1, 2'd3, 5'h09, 128'h0000000000000000_8000000000000001},
    {1'b1, 1'b0, 2'd0, 5'h0A, 128'h807F0001FF10F000_0102FF0405FE0708},
    {1'b1, 1'b0, 2'd0, 5'h0B, 128'h807F0001FF10F000_81FE7F0002FD0380},
    {1'b1, 1'b1, 2'd1, 5'h0B, 128'h80007FFF0000FFFF_0001800100020000},
    {1'b1, 1'b0, 2'd3, 5'h0B, 128'h8000000000000000_FFFFFFFFFFFFFFFB},
    {1'b0, 1'b1, 2'd2, 5'h0B, 128'h12345678_9ABCDEF0_80000000_00000001},
    {1'b0, 1'b0, 2'd3, 5'h08, 128'h0000000000000005_0000000000000007},
    {1'b1, 1'b0, 2'd2, 5'h05, 128'hFFFFFFFF_00000001_00000000_80000000},
    {1'b0, 1'b1, 2'd0, 5'h09, 128'hFFFFFFFFFFFFFFFF_00FF7F8001020304},
    {1'b1, 1'b1, 2'd3, 5'h0B, 128'h8000000000000000_0000000000000001},
    {1'b1, 1'b0, 2'd2, 5'h0A, 128'h80000000_7FFFFFFF_00000000_FFFFFFFF},
    {1'b0, 1'b0, 2'd1, 5'h0B, 128'hAAAA5555AAAA5555_8000FFFF7FFF0001},
    {1'b1, 1'b0, 2'd1, 5'h09, 128'h00000001_00010000_0000FFFF_0000F000}
  };

  function automatic logic [31:0] mk(logic q, logic u, logic [1:0] sz,
                                     logic [4:0] op, logic [4:0] rn, logic [4:0] rd);
    return {1'b0, q, u, 5'b0, sz, 5'b0, op, 2'b0, rn, rd};
  endfunction

  // independent reference model built from the requirements
  function automatic logic [127:0] model(logic q, logic u, logic [1:0] sz,
                                         logic [4:0] op, logic [127:0] s);
    int ew;
    int nl;
    logic [127:0] r;
    ew = 8 << sz;
    nl = (q ? 128 : 64) / ew;
    r  = '0;
    if (op < 5'h08 || op > 5'h0B) return '0;
    if (sz == 2'd3 && !q) return '0;
    for (int i = 0; i < nl; i++) begin
      logic [63:0] m, v, o, ng;
      logic signed [64:0] sv;
      logic hit;
      m  = (ew == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << ew) - 64'd1);
      v  = 64'(s >> (i * ew)) & m;
      sv = v[ew-1] ? $signed({1'b1, v | ~m}) : $signed({1'b0, v});
      ng = (~v + 64'd1) & m;
      hit = 1'b0;
      o = '0;
      case (op)
        5'h08: hit = u ? (sv >= 0) : (sv > 0);
        5'h09: hit = u ? (sv <= 0) : (sv == 0);
        5'h0A: hit = (sv < 0);
        default: hit = 1'b0;
      endcase
      if (op == 5'h0B) o = u ? ng : ((sv > 0) ? v : ng);
      else             o = hit ? m : 64'd0;
      r = r | (128'(o) << (i * ew));
    end
    return r;
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, output registered at next posedge, sample at following negedge
  task automatic issue(logic [31:0] ins, logic [127:0] s);
    @(negedge clk);
    in_valid = 1'b1;
    instr = ins;
    src = s;
    #1;
    check("R1 src_idx", 128'(src_idx), 128'(ins[9:5]));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 reset result", result, '0);
    check("R10 reset flags", 128'({out_valid, wr_en, undef_flag, unsup_flag, rd_idx}), '0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      logic q, u;
      logic [1:0] sz;
      logic [4:0] op, rd;
      logic [127:0] s, exp;
      logic e_undef, e_unsup;
      {q, u, sz, op, s} = VEC[k];
      rd = 5'(k + 3);
      exp = model(q, u, sz, op, s);
      e_unsup = (op < 5'h08 || op > 5'h0B);
      e_undef = !e_unsup && sz == 2'd3 && !q;
      issue(mk(q, u, sz, op, 5'(31 - k), rd), s);
      // tags: R2 R3 R4 R5 R8 R9 covered by the model per entry
      check($sformatf("R2/R3/R4/R5/R8/R9 vec%0d result", k), result, exp);
      check("R10 out_valid", 128'(out_valid), 128'(1));
      check("R6 R7 wr_en", 128'(wr_en), 128'(!e_undef && !e_unsup));
      check("R6 undef_flag", 128'(undef_flag), 128'(e_undef));
      check("R7 unsup_flag", 128'(unsup_flag), 128'(e_unsup));
      check("R1 rd_idx", 128'(rd_idx), 128'(rd));
      #10;
      check("R10 idle out_valid", 128'(out_valid), 128'(0));
    end

    // R4 directed: most negative byte keeps its value under absolute value
    issue(mk(1'b1, 1'b0, 2'd0, 5'h0B, 5'd1, 5'd2), {16{8'h80}});
    check("R4 abs min byte", result, {16{8'h80}});
    // R5 directed: negate 32-bit lanes, wrap of minimum
    issue(mk(1'b1, 1'b1, 2'd2, 5'h0B, 5'd1, 5'd2), 128'h80000000_00000001_FFFFFFFF_00000000);
    check("R5 neg 32", result, 128'h80000000_FFFFFFFF_00000001_00000000);
    // R3 directed: less-than on 16-bit, zero gives false, minus one gives true
    issue(mk(1'b1, 1'b0, 2'd1, 5'h0A, 5'd1, 5'd2), 128'h0000_FFFF_8000_7FFF_0001_0000_FFFE_0000);
    check("R3 lt 16", result, 128'h0000_FFFF_FFFF_0000_0000_0000_FFFF_0000);
    // R9 directed: 16-bit negate of 0x0100 must not borrow from its neighbours
    issue(mk(1'b1, 1'b1, 2'd1, 5'h0B, 5'd1, 5'd2), 128'h0000_0100_0000_0100_0000_0100_0000_0100);
    check("R9 no borrow", result, 128'h0000_FF00_0000_FF00_0000_FF00_0000_FF00);
    // R8 directed: half-width equality, upper zero even though the upper source is zero
    issue(mk(1'b0, 1'b0, 2'd0, 5'h09, 5'd1, 5'd2), '0);
    check("R8 half eq", result, {64'd0, {8{8'hFF}}});

    // R10 back-to-back: second result appears one cycle after the first
    @(negedge clk);
    in_valid = 1'b1; instr = mk(1'b1, 1'b1, 2'd2, 5'h0B, 5'd0, 5'd7); src = 128'd1;
    @(negedge clk);
    check("R10 b2b first", result, {96'd0, 32'hFFFFFFFF});
    instr = mk(1'b1, 1'b0, 2'd2, 5'h08, 5'd0, 5'd9); src = 128'd1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 b2b second", result, {96'd0, 32'hFFFFFFFF});
    check("R10 b2b rd", 128'(rd_idx), 128'd9);
    @(negedge clk);
    check("R10 drop", 128'({out_valid, wr_en}), '0);

    finish_run();
  end
endmodule